// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register Block

This block is the register file that sits between a host and up to eight DMA data movers. The host reaches it through a simple 32-bit word bus. The bus has a write strobe, an address and write data, and its read data is combinational. Several words are shared by all channels, and each channel owns a narrow field inside them. One word carries every channel's transfer mode and direction. Another carries the interrupt enables and the start requests. A status word collects each channel's completion flag, its error flag and a live copy of the state the channel reports. Each channel also has four free-form descriptor words, which are passed straight to its mover.

On the channel side, the block drives each mover's mode, direction and a one-cycle start pulse. It also drives the descriptor words. From each mover it takes a 2-bit state, a done pulse and an error qualifier. One interrupt line is raised whenever any channel has a pending completion whose enable is set. Software clears the flags by writing ones back to the status word.

Top module: `dmac_regfile`

## Requirements
- R1: After reset, the mode, direction, enable, control-1, completion and error registers are all zero. The outputs `ch_mode`, `ch_dir`, `ch_start` and `irq_out` are zero.
- R2: The word at offset 0x00 holds a 4-bit field for channel n at bits 4n+3..4n. Field bits 1..0 are the mode (0 off, 1 descriptor chain, 2 single transfer), and they drive `ch_mode[2n+1:2n]`. Field bit 2 is the direction (1 means memory to device), and it drives `ch_dir[n]`. Field bit 3 reads back as zero.
- R3: In the word at offset 0x08, bits 7..0 are interrupt enables (bit n for channel n) and read back as written. Bits 15..8 are start requests and always read as zero.
- R4: Suppose a write to 0x08 has bit 8+n set while `ch_state[2n+1:2n]` is 0 (idle). Then `ch_start[n]` is 1 for exactly the cycle after that write. If the channel's state is not idle, the request is ignored.
- R5: A cycle with `ch_done[n]` high sets completion flag n, which is status bit n at offset 0x10. If `ch_err[n]` is also high, it sets error flag n, which is status bit 8+n. `ch_err[n]` without `ch_done[n]` sets nothing.
- R6: A write to 0x10 clears every completion or error flag whose bit in the written value is 1, and leaves the other flags alone. When a flag is set and cleared in the same cycle, the set wins.
- R7: Status bits 16+2n+1..16+2n always show the present `ch_state[2n+1:2n]`. Status bits for absent channels read as zero. Writes to the state field have no effect.
- R8: `irq_out` is 1 exactly when some channel n has both completion flag n and enable bit n set.
- R9: The word at 0x04 is a plain 32-bit read/write word. Offsets 0x0C and 0x14 read as zero.
- R10: Descriptor word k (0..3) of channel n sits at offset 0x20+16n+4k. It reads back as written and drives `ch_desc[(4n+k)*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address (bits 1..0 ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ch_state | input | 2*NCH | Per-channel state: 0 idle, 1 descriptor read, 2 waiting, 3 accessing |
| ch_done | input | NCH | Per-channel completion pulse |
| ch_err | input | NCH | Per-channel error qualifier for `ch_done` |
| ch_mode | output | 2*NCH | Per-channel mode |
| ch_dir | output | NCH | Per-channel direction |
| ch_start | output | NCH | Per-channel one-cycle start pulse |
| ch_desc | output | 128*NCH | Descriptor words of all channels |
| irq_out | output | 1 | Combined interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a flag being set by a done pulse in the same cycle that software writes a one to clear it. The bench reaches it by driving `ch_done` and the status write on the same falling edge, and then reads the flag back. The second is a start request that arrives while a channel is busy. The bench holds `ch_state` at each non-idle value in turn and confirms that no pulse appears. The interrupt combine is swept over all 256 enable masks against four different flag patterns.

// File: rtl/dmac_regfile.sv
module dmac_regfile #(
  parameter int NCH    = 8,
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wen,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  input  logic [2*NCH-1:0]      ch_state,
  input  logic [NCH-1:0]        ch_done,
  input  logic [NCH-1:0]        ch_err,
  output logic [2*NCH-1:0]      ch_mode,
  output logic [NCH-1:0]        ch_dir,
  output logic [NCH-1:0]        ch_start,
  output logic [128*NCH-1:0]    ch_desc,
  output logic                  irq_out
);
  localparam int NDESC = 4 * NCH;
  localparam int DW    = $clog2(NDESC);
  localparam logic [ADDR_W-1:0] A_CTL0 = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTL1 = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CTL2 = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STS0 = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_DESC = ADDR_W'(8'h20);

  logic [2*NCH-1:0] mode_q;
  logic [NCH-1:0]   dir_q, ien_q, irqf_q, errf_q, start_q;
  logic [31:0]      ctl1_q;
  logic [31:0]      desc_q [NDESC];

  logic [ADDR_W-1:0] a, doff;
  logic [ADDR_W-3:0] didx;
  logic              dhit, w_ctl0, w_ctl2, w_sts0;
  logic [NCH-1:0]    idle;

  assign a      = {bus_addr[ADDR_W-1:2], 2'b00};
  assign doff   = a - A_DESC;
  assign didx   = doff[ADDR_W-1:2];
  assign dhit   = (a >= A_DESC) && (didx < (ADDR_W-2)'(NDESC));
  assign w_ctl0 = bus_wen && a == A_CTL0;
  assign w_ctl2 = bus_wen && a == A_CTL2;
  assign w_sts0 = bus_wen && a == A_STS0;

  assign ch_mode  = mode_q;
  assign ch_dir   = dir_q;
  assign ch_start = start_q;
  assign irq_out  = |(irqf_q & ien_q);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign idle[i] = ch_state[2*i +: 2] == 2'd0;
    for (genvar k = 0; k < 4; k++) begin : g_w
      assign ch_desc[(4*i+k)*32 +: 32] = desc_q[4*i+k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      irqf_q  <= '0;
      errf_q  <= '0;
      start_q <= '0;
      ctl1_q  <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (w_ctl0) begin
          mode_q[2*i +: 2] <= bus_wdata[4*i +: 2];
          dir_q[i]         <= bus_wdata[4*i+2];
        end
        start_q[i] <= w_ctl2 && bus_wdata[8+i] && idle[i];
        irqf_q[i]  <= ch_done[i] | (irqf_q[i] & ~(w_sts0 & bus_wdata[i]));
        errf_q[i]  <= (ch_done[i] & ch_err[i]) | (errf_q[i] & ~(w_sts0 & bus_wdata[8+i]));
      end
      if (w_ctl2) ien_q <= bus_wdata[NCH-1:0];
      if (bus_wen && a == A_CTL1) ctl1_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (bus_wen && dhit) desc_q[didx[DW-1:0]] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (a == A_CTL0) begin
      for (int i = 0; i < NCH; i++) begin
        bus_rdata[4*i +: 2] = mode_q[2*i +: 2];
        bus_rdata[4*i+2]    = dir_q[i];
      end
    end else if (a == A_CTL1) begin
      bus_rdata = ctl1_q;
    end else if (a == A_CTL2) begin
      bus_rdata[NCH-1:0] = ien_q;
    end else if (a == A_STS0) begin
      bus_rdata[NCH-1:0]      = irqf_q;
      bus_rdata[8 +: NCH]     = errf_q;
      bus_rdata[16 +: 2*NCH]  = ch_state;
    end else if (dhit) begin
      bus_rdata = desc_q[didx[DW-1:0]];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ast
    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      ch_start[i] |-> $past(w_ctl2 && bus_wdata[8+i] && ch_state[2*i +: 2] == 2'd0)); // R4
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(errf_q[i]) |-> $past(ch_done[i] && ch_err[i])); // R5
    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irqf_q[i]) |-> $past(w_sts0 && bus_wdata[i] && !ch_done[i])); // R6
  end
  AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_mode) |-> $past(w_ctl0)); // R2
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq_out); // R8
endmodule

// File: tb/dmac_regfile_test.sv
module dmac_regfile_test;
  localparam int NCH = 8;
  logic clk = 0, rst_n = 0, bus_wen = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] ch_state = 0;
  logic [7:0]  ch_done = 0, ch_err = 0;
  logic [15:0] ch_mode;
  logic [7:0]  ch_dir, ch_start;
  logic [1023:0] ch_desc;
  logic irq_out;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  dmac_regfile #(.NCH(NCH), .ADDR_W(8)) uut (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] ad, logic [31:0] d);
    @(negedge clk); bus_wen = 1; bus_addr = ad; bus_wdata = d;
    @(negedge clk); bus_wen = 0;
  endtask

  task automatic rd(logic [7:0] ad, output logic [31:0] d);
    bus_addr = ad; #1; d = bus_rdata;
  endtask

  task automatic pulse(logic [7:0] dn, logic [7:0] er);
    @(negedge clk); ch_done = dn; ch_err = er;
    @(negedge clk); ch_done = 0; ch_err = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, w, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 ctl0", r, 0);
    rd(8'h04, r); check("R1 ctl1", r, 0);
    rd(8'h08, r); check("R1 ctl2", r, 0);
    rd(8'h10, r); check("R1 sts0", r, 0);
    check("R1 outputs", {ch_mode, ch_dir, ch_start, 7'd0, irq_out}, 0);

    // R2 sweep of per-channel mode/direction fields
    for (int v = 0; v < 16; v++) begin
      w = 0;
      for (int i = 0; i < NCH; i++) w |= 32'((v + i) & 15) << (4 * i);
      wr(8'h00, w);
      rd(8'h00, r); check("R2 readback", r, w & 32'h7777_7777);
      for (int i = 0; i < NCH; i++) begin
        check("R2 mode out", 32'(ch_mode[2*i +: 2]), 32'((v + i) & 3));
        check("R2 dir out", 32'(ch_dir[i]), 32'(((v + i) >> 2) & 1));
      end
    end

    // R3 enables read back, start bits read zero (channels busy: no pulses)
    ch_state = 16'hFFFF;
    wr(8'h08, 32'hFFFF_FFA5);
    rd(8'h08, r); check("R3 ctl2 readback", r, 32'h0000_00A5);
    wr(8'h08, 0);

    // R4 start pulse when idle, ignored when busy
    for (int ch = 0; ch < NCH; ch++) begin
      ch_state = 0;
      wr(8'h08, 32'h100 << ch);
      check("R4 start pulse", 32'(ch_start), 32'(1) << ch);
      @(negedge clk);
      check("R4 pulse one cycle", 32'(ch_start), 0);
      for (int s = 1; s < 4; s++) begin
        ch_state = 16'(s) << (2 * ch);
        wr(8'h08, 32'hFF00);
        check("R4 busy start ignored", 32'(ch_start), 32'hFF & ~(32'(1) << ch));
      end
    end
    ch_state = 0;
    wr(8'h08, 0);

    // R5/R6 per-channel flags
    for (int ch = 0; ch < NCH; ch++) begin
      pulse(0, 8'(1 << ch));
      rd(8'h10, r); check("R5 err alone ignored", r, 0);
      pulse(8'(1 << ch), 8'(1 << ch));
      rd(8'h10, r); check("R5 done+err", r, 32'h101 << ch);
      wr(8'h10, 32'h100 << ch);
      rd(8'h10, r); check("R6 clear err only", r, 32'h1 << ch);
      wr(8'h10, ~(32'h1 << ch) & 32'hFFFF);
      rd(8'h10, r); check("R6 zero bits keep flag", r, 32'h1 << ch);
      @(negedge clk); ch_done = 8'(1 << ch); bus_wen = 1; bus_addr = 8'h10; bus_wdata = 32'h1 << ch;
      @(negedge clk); ch_done = 0; bus_wen = 0;
      rd(8'h10, r); check("R6 set wins over clear", r, 32'h1 << ch);
      wr(8'h10, 32'hFFFF);
      rd(8'h10, r); check("R6 cleared", r, 0);
    end

    // R7 live state mirror
    for (int p = 0; p < 16; p++) begin
      ch_state = 16'(p * 16'h1111 ^ 16'h5A3C);
      wr(8'h10, 32'hFFFF_0000);
      rd(8'h10, r); check("R7 state mirror", r, {ch_state, 16'h0});
    end
    ch_state = 0;

    // R8 interrupt combine sweep
    for (int fi = 0; fi < 4; fi++) begin
      logic [7:0] f;
      f = (fi == 0) ? 8'h01 : (fi == 1) ? 8'h80 : (fi == 2) ? 8'h5A : 8'hFF;
      wr(8'h10, 32'hFFFF);
      pulse(f, 0);
      for (int en = 0; en < 256; en++) begin
        wr(8'h08, 32'(en));
        check("R8 irq combine", 32'(irq_out), 32'(|(f & 8'(en))));
      end
    end
    wr(8'h08, 0);
    wr(8'h10, 32'hFFFF);

    // R9 control 1 and zero-reading words
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, r); check("R9 ctl1", r, 32'hDEAD_BEEF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, r); check("R9 sts1 zero", r, 0);
    rd(8'h0C, r); check("R9 0x0C zero", r, 0);

    // R10 descriptor words: write all, then read all
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 4; k++)
        wr(8'(32 + 16 * ch + 4 * k), 32'hC000_0000 | 32'(ch << 12) | 32'(k * 17 + 3));
    for (int ch = 0; ch < NCH; ch++)
      for (int k = 0; k < 4; k++) begin
        e = 32'hC000_0000 | 32'(ch << 12) | 32'(k * 17 + 3);
        rd(8'(32 + 16 * ch + 4 * k), r); check("R10 desc readback", r, e);
        check("R10 desc output", ch_desc[(4*ch+k)*32 +: 32], e);
      end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule